// File: doc/BRIEF.md
# Keyed Flash Erase/Program Sequencer

This block turns register writes into erase and program operations on an embedded flash array. Software loads a row buffer through a valid/ready write stream. It selects the target with a page-select register and the in-page offset of the last buffer write. It fills a control word with an operation code, an erase flag and a write-enable flag. It then sets the start bit. A start is honoured only when the key register has just received the two-value unlock pair. The unlock state is consumed by every start attempt, so each operation needs its own key pair.

An accepted erase clears one page of eight 64-word rows. An accepted program sends the 64 buffered words to the array as a valid/ready stream, then waits out the program time. While either operation runs, busy and stall are high, the buffer stream is held off, and all register writes are dropped. The start bit falls back to zero when the operation ends.

Buffer stream rules: `bw_ready` is high exactly when the block is idle, and a word is taken on a cycle with `bw_valid` and `bw_ready` both high. Array stream rules: `arr_wvalid` stays high and `arr_widx`/`arr_wdata` stay unchanged until `arr_wready` is seen. The array may hold `arr_wready` low for any number of cycles.

Top module: `flc_ctrl`

## Requirements
- R1: After reset the control read-back is 0x0000, busy, stall and the key error flag are low, and `bw_ready` is high.
- R2: Register addresses are 0 = control, 1 = key, 2 = page select. A start (control bit 15) is armed only when the two writes just before it were key writes of 0x0055 and then 0x00AA.
- R3: Any other key value, or any other register or buffer write after either key, clears the unlock state. A start while not armed is ignored, and it sets the sticky key error flag, which only reset clears.
- R4: Control bits 3:0 = 4'b0010 with erase flag (bit 6) set and write-enable (bit 14) set, when armed, starts a page erase. `arr_erase` is high for exactly T_ERASE cycles. `arr_page` is the 24-bit target {page select, offset} shifted right by 9.
- R5: Code 4'b0001 with the erase flag clear and write-enable set, when armed and with all 64 buffer slots written since the last program, starts a row program. `arr_row` is the target shifted right by 6. The 64 words stream out in index order 0..63. After the last word is taken, the program continues for T_PROG more cycles. An accepted program empties the slot record.
- R6: A start with write-enable clear, an unknown code/flag combination, or a program with an incomplete buffer is rejected. No array signal rises, the start bit reads 0, and the key error flag is not touched.
- R7: Busy and stall are high from the cycle after an accepted start until the operation ends. The start bit reads 1 over exactly that span and clears by itself at the end.
- R8: While busy, writes to every register, including keys, are dropped, `bw_ready` is low, and the control fields and target address do not change.
- R9: Each start attempt consumes the unlock state. A second start needs a fresh key pair.
- R10: A buffer write stores its data in slot offset[5:0] and latches the full 16-bit offset as the low half of the target address.
- R11: While `arr_wready` is low, `arr_wvalid` stays high and the offered index and word stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 key, 2 page select |
| reg_wdata | input | 16 | Register write data |
| bw_valid | input | 1 | Buffer word offered |
| bw_ready | output | 1 | Buffer word can be taken (idle) |
| bw_offset | input | OFS_W | In-page word offset of the buffer word |
| bw_data | input | DATA_W | Buffer word |
| ctrl_rd | output | 16 | Control register read-back |
| busy | output | 1 | Operation in progress |
| stall | output | 1 | Stall request to the processor |
| key_err | output | 1 | Sticky start-without-unlock flag |
| arr_erase | output | 1 | Page erase in progress |
| arr_prog | output | 1 | Row program in progress |
| arr_page | output | PSEL_W+OFS_W-9 | Page index of the target |
| arr_row | output | PSEL_W+OFS_W-6 | Row index of the target |
| arr_wvalid | output | 1 | Row word offered to the array |
| arr_wready | input | 1 | Array takes the offered word |
| arr_widx | output | 6 | Index of the offered word within the row |
| arr_wdata | output | DATA_W | Offered row word |

## Verification
The bench builds the block with T_ERASE = 9 and T_PROG = 4. With these values, completion, start-bit self-clear and the end of the write freeze arrive within a few dozen cycles of each start. The row size stays at 64 words and the page at 8 rows, with an 8-bit page select and a 16-bit offset. The bench can therefore check the real page and row splits of the target address and a full 64-word stream. The array-side ready follows a repeating pattern with gaps, so the word hold under back-pressure is exercised on every program.

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_KEY  = 2'd1,
    RA_PSEL = 2'd2
  } reg_addr_e;

  typedef enum logic [1:0] {
    UL_NONE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_STREAM = 2'd1,
    SQ_WAIT   = 2'd2
  } seq_e;

  localparam logic [15:0] KEY_FIRST  = 16'h0055;
  localparam logic [15:0] KEY_SECOND = 16'h00AA;
  localparam logic [3:0]  OP_ERASE   = 4'b0010;
  localparam logic [3:0]  OP_PROG    = 4'b0001;
  localparam int BIT_START = 15;
  localparam int BIT_WREN  = 14;
  localparam int BIT_ERASE = 6;
endpackage

// File: rtl/flc_key_gate.sv
module flc_key_gate
  import flc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [15:0] key_val,
  input  logic        other_we,
  output logic        armed
);
  unlock_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= UL_NONE;
    end else if (other_we) begin
      st_q <= UL_NONE;
    end else if (key_we) begin
      if (key_val == KEY_FIRST)
        st_q <= UL_HALF;
      else if (key_val == KEY_SECOND && st_q == UL_HALF)
        st_q <= UL_ARMED;
      else
        st_q <= UL_NONE;
    end
  end

  assign armed = (st_q == UL_ARMED);

  // R9: any non-key write leaves the gate disarmed
  a_r9_other_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    other_we |=> !armed);
  // R2: the armed state is only reached through a key write
  a_r2_arm_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(key_we));
endmodule

// File: rtl/flc_row_buf.sv
module flc_row_buf #(
  parameter int DATA_W    = 24,
  parameter int ROW_WORDS = 64,
  localparam int IDX_W    = $clog2(ROW_WORDS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              full
);
  logic [DATA_W-1:0]    mem [ROW_WORDS];
  logic [ROW_WORDS-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   seen_q <= '0;
    else if (clr) seen_q <= '0;
    else if (we)  seen_q[widx] <= 1'b1;
  end

  assign rdata = mem[ridx];
  assign full  = &seen_q;

  // R5: an accepted program leaves the slot record empty
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !we) |=> !full);
endmodule

// File: rtl/flc_seq.sv
module flc_seq
  import flc_pkg::*;
#(
  parameter int ROW_WORDS = 64,
  parameter int T_ERASE   = 64,
  parameter int T_PROG    = 32,
  localparam int IDX_W    = $clog2(ROW_WORDS),
  localparam int T_MAX    = (T_ERASE > T_PROG) ? T_ERASE : T_PROG,
  localparam int CNT_W    = $clog2(T_MAX + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_erase,
  input  logic             go_prog,
  input  logic             wready,
  output logic             busy,
  output logic             erasing,
  output logic             programming,
  output logic             wvalid,
  output logic [IDX_W-1:0] widx,
  output logic             done
);
  seq_e             st_q;
  logic             kind_erase_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= SQ_IDLE;
      kind_erase_q <= 1'b0;
      idx_q        <= '0;
      cnt_q        <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (go_erase) begin
            st_q         <= SQ_WAIT;
            kind_erase_q <= 1'b1;
            cnt_q        <= CNT_W'(T_ERASE - 1);
          end else if (go_prog) begin
            st_q         <= SQ_STREAM;
            kind_erase_q <= 1'b0;
            idx_q        <= '0;
          end
        end
        SQ_STREAM: begin
          if (wready) begin
            if (idx_q == IDX_W'(ROW_WORDS - 1)) begin
              st_q  <= SQ_WAIT;
              cnt_q <= CNT_W'(T_PROG - 1);
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        SQ_WAIT: begin
          if (cnt_q == '0) st_q <= SQ_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != SQ_IDLE);
  assign erasing     = busy && kind_erase_q;
  assign programming = busy && !kind_erase_q;
  assign wvalid      = (st_q == SQ_STREAM);
  assign widx        = idx_q;
  assign done        = (st_q == SQ_WAIT) && (cnt_q == '0);

  // R11: an offered word is held until the array takes it
  a_r11_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(widx)));
  // R7: completion returns the sequencer to idle
  a_r7_done_idles: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R5: the stream always begins at word 0
  a_r5_stream_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wvalid) |-> (widx == '0));
endmodule

// File: rtl/flc_ctrl.sv
module flc_ctrl
  import flc_pkg::*;
#(
  parameter int DATA_W        = 24,
  parameter int ROW_WORDS     = 64,
  parameter int ROWS_PER_PAGE = 8,
  parameter int PSEL_W        = 8,
  parameter int OFS_W         = 16,
  parameter int T_ERASE       = 64,
  parameter int T_PROG        = 32,
  localparam int IDX_W        = $clog2(ROW_WORDS),
  localparam int PAGE_SH      = $clog2(ROW_WORDS * ROWS_PER_PAGE),
  localparam int TGT_W        = PSEL_W + OFS_W,
  localparam int PAGE_W       = TGT_W - PAGE_SH,
  localparam int ROW_W        = TGT_W - IDX_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  input  logic              bw_valid,
  output logic              bw_ready,
  input  logic [OFS_W-1:0]  bw_offset,
  input  logic [DATA_W-1:0] bw_data,
  output logic [15:0]       ctrl_rd,
  output logic              busy,
  output logic              stall,
  output logic              key_err,
  output logic              arr_erase,
  output logic              arr_prog,
  output logic [PAGE_W-1:0] arr_page,
  output logic [ROW_W-1:0]  arr_row,
  output logic              arr_wvalid,
  input  logic              arr_wready,
  output logic [IDX_W-1:0]  arr_widx,
  output logic [DATA_W-1:0] arr_wdata
);
  logic busy_i, done_i, armed_i, buf_full;
  logic reg_fire, ctrl_we, key_we, psel_we, other_we, bw_fire;
  logic want_erase, want_prog, accept, go_erase, go_prog, start_req;
  logic [3:0]        op_q;
  logic              erase_q, wren_q, start_q, err_q;
  logic [PSEL_W-1:0] psel_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [TGT_W-1:0]  target;

  assign reg_fire = reg_we && !busy_i;
  assign ctrl_we  = reg_fire && (reg_addr == RA_CTRL);
  assign key_we   = reg_fire && (reg_addr == RA_KEY);
  assign psel_we  = reg_fire && (reg_addr == RA_PSEL);
  assign bw_ready = !busy_i;
  assign bw_fire  = bw_valid && bw_ready;
  assign other_we = (reg_fire && (reg_addr != RA_KEY)) || bw_fire;

  flc_key_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (key_we),
    .key_val  (reg_wdata),
    .other_we (other_we),
    .armed    (armed_i)
  );

  assign start_req  = ctrl_we && reg_wdata[BIT_START];
  assign want_erase = (reg_wdata[3:0] == OP_ERASE) && reg_wdata[BIT_ERASE];
  assign want_prog  = (reg_wdata[3:0] == OP_PROG) && !reg_wdata[BIT_ERASE] && buf_full;
  assign accept     = start_req && armed_i && !bw_fire && reg_wdata[BIT_WREN]
                      && (want_erase || want_prog);
  assign go_erase   = accept && want_erase;
  assign go_prog    = accept && want_prog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= '0;
      erase_q <= 1'b0;
      wren_q  <= 1'b0;
      start_q <= 1'b0;
    end else if (ctrl_we) begin
      op_q    <= reg_wdata[3:0];
      erase_q <= reg_wdata[BIT_ERASE];
      wren_q  <= reg_wdata[BIT_WREN];
      start_q <= accept;
    end else if (done_i) begin
      start_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                    err_q <= 1'b0;
    else if (start_req && !(armed_i && !bw_fire))  err_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psel_q <= '0;
      ofs_q  <= '0;
    end else begin
      if (psel_we) psel_q <= reg_wdata[PSEL_W-1:0];
      if (bw_fire) ofs_q  <= bw_offset;
    end
  end

  flc_row_buf #(.DATA_W(DATA_W), .ROW_WORDS(ROW_WORDS)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bw_fire),
    .widx  (bw_offset[IDX_W-1:0]),
    .wdata (bw_data),
    .clr   (go_prog),
    .ridx  (arr_widx),
    .rdata (arr_wdata),
    .full  (buf_full)
  );

  flc_seq #(.ROW_WORDS(ROW_WORDS), .T_ERASE(T_ERASE), .T_PROG(T_PROG)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_erase    (go_erase),
    .go_prog     (go_prog),
    .wready      (arr_wready),
    .busy        (busy_i),
    .erasing     (arr_erase),
    .programming (arr_prog),
    .wvalid      (arr_wvalid),
    .widx        (arr_widx),
    .done        (done_i)
  );

  assign target   = {psel_q, ofs_q};
  assign arr_page = target[TGT_W-1:PAGE_SH];
  assign arr_row  = target[TGT_W-1:IDX_W];
  assign busy     = busy_i;
  assign stall    = busy_i;
  assign key_err  = err_q;
  assign ctrl_rd  = {start_q, wren_q, 7'b0, erase_q, 2'b0, op_q};

  // R7: the start bit reads 1 exactly while an operation runs
  a_r7_start_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_q == busy_i);
  // R6: a rejected start never launches the array
  a_r6_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !accept) |=> !busy_i);
  // R8: control fields and target are frozen while busy
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(op_q) && $stable(psel_q) && $stable(ofs_q) && $stable(wren_q)));
  // R3: the key error flag is sticky
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: tb/sim_flc_ctrl.sv
`timescale 1ns/100ps
module sim_flc_ctrl;
  localparam int DW = 24, RW = 64, RPP = 8, PW = 8, OW = 16, TE = 9, TP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, bw_valid = 1'b0, arr_wready = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, ctrl_rd;
  logic [OW-1:0] bw_offset = '0;
  logic [DW-1:0] bw_data = '0, arr_wdata;
  logic bw_ready, busy, stall, key_err, arr_erase, arr_prog, arr_wvalid;
  logic [14:0] arr_page;
  logic [17:0] arr_row;
  logic [5:0]  arr_widx;

  flc_ctrl #(.DATA_W(DW), .ROW_WORDS(RW), .ROWS_PER_PAGE(RPP), .PSEL_W(PW),
             .OFS_W(OW), .T_ERASE(TE), .T_PROG(TP)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bw_valid(bw_valid), .bw_ready(bw_ready),
    .bw_offset(bw_offset), .bw_data(bw_data), .ctrl_rd(ctrl_rd), .busy(busy),
    .stall(stall), .key_err(key_err), .arr_erase(arr_erase), .arr_prog(arr_prog),
    .arr_page(arr_page), .arr_row(arr_row), .arr_wvalid(arr_wvalid),
    .arr_wready(arr_wready), .arr_widx(arr_widx), .arr_wdata(arr_wdata));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_unl, m_st, m_idx, m_cnt;
  bit m_err, m_start, m_wren, m_er, m_kind_e;
  bit [3:0]  m_op;
  bit [7:0]  m_psel;
  bit [15:0] m_ofs;
  bit [23:0] m_mem [64];
  bit        m_fill [64];

  always @(posedge clk) begin
    bit bz, bf, rf, armed, full, acc, e_ok, p_ok;
    if (!rst_n) begin
      m_unl = 0; m_st = 0; m_idx = 0; m_cnt = 0;
      m_err = 0; m_start = 0; m_wren = 0; m_er = 0; m_kind_e = 0;
      m_op = 0; m_psel = 0; m_ofs = 0;
      foreach (m_fill[i]) m_fill[i] = 0;
    end else begin
      bz = (m_st != 0);
      rf = reg_we && !bz;
      bf = bw_valid && !bz;
      armed = (m_unl == 2) && !bf;
      full = 1;
      foreach (m_fill[i]) if (!m_fill[i]) full = 0;
      if (m_st == 1) begin
        if (arr_wready) begin
          if (m_idx == RW - 1) begin m_st = 2; m_cnt = TP - 1; end
          else m_idx++;
        end
      end else if (m_st == 2) begin
        if (m_cnt == 0) begin m_st = 0; m_start = 0; end
        else m_cnt--;
      end
      if (rf && reg_addr == 2'd0) begin
        m_op = reg_wdata[3:0]; m_er = reg_wdata[6]; m_wren = reg_wdata[14];
        e_ok = (reg_wdata[3:0] == 4'b0010) && reg_wdata[6];
        p_ok = (reg_wdata[3:0] == 4'b0001) && !reg_wdata[6] && full;
        acc = reg_wdata[15] && armed && reg_wdata[14] && (e_ok || p_ok);
        if (reg_wdata[15] && !armed) m_err = 1;
        m_start = acc;
        if (acc && e_ok) begin m_st = 2; m_kind_e = 1; m_cnt = TE - 1; end
        if (acc && p_ok) begin
          m_st = 1; m_kind_e = 0; m_idx = 0;
          foreach (m_fill[i]) m_fill[i] = 0;
        end
      end
      if (rf && reg_addr == 2'd2) m_psel = reg_wdata[7:0];
      if (bf || (rf && reg_addr != 2'd1)) m_unl = 0;
      else if (rf) begin
        if (reg_wdata == 16'h0055) m_unl = 1;
        else if (reg_wdata == 16'h00AA && m_unl == 1) m_unl = 2;
        else m_unl = 0;
      end
      if (bf) begin
        m_mem[bw_offset[5:0]] = bw_data;
        m_fill[bw_offset[5:0]] = 1;
        m_ofs = bw_offset;
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 ctrl_rd", ctrl_rd, {m_start, m_wren, 7'b0, m_er, 2'b0, m_op});
      chk("R7 busy", busy, m_st != 0);
      chk("R7 stall", stall, m_st != 0);
      chk("R3 key_err", key_err, m_err);
      chk("R8 bw_ready", bw_ready, m_st == 0);
      chk("R4 arr_erase", arr_erase, (m_st != 0) && m_kind_e);
      chk("R5 arr_prog", arr_prog, (m_st != 0) && !m_kind_e);
      chk("R11 arr_wvalid", arr_wvalid, m_st == 1);
      if (m_st == 1) begin
        chk("R11 arr_widx", arr_widx, m_idx);
        chk("R5 arr_wdata", arr_wdata, m_mem[m_idx]);
      end
      if (m_st != 0 && m_kind_e) chk("R4 arr_page", arr_page, {m_psel, m_ofs} >> 9);
      if (m_st != 0 && !m_kind_e) chk("R10 arr_row", arr_row, {m_psel, m_ofs} >> 6);
    end
  end

  // array-side ready with gaps
  always @(negedge clk) arr_wready <= ((cyc % 5) != 1) && ((cyc % 7) != 3);

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL R7 watchdog actual=%0d expected<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic rw(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic bw(input logic [15:0] ofs, input logic [23:0] d);
    bw_valid = 1'b1; bw_offset = ofs; bw_data = d;
    @(negedge clk);
    bw_valid = 1'b0;
  endtask

  task automatic keys();
    rw(2'd1, 16'h0055);
    rw(2'd1, 16'h00AA);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl_rd", ctrl_rd, 16'h0000);
    chk("R1 busy", busy, 0);
    chk("R1 key_err", key_err, 0);
    chk("R1 bw_ready", bw_ready, 1);

    // R2/R4: keyed page erase, R10 target from page select and offset
    rw(2'd2, 16'h0003);
    bw(16'h0A40, 24'h123456);
    keys();
    rw(2'd0, 16'hC042);
    chk("R2 erase accepted", busy, 1);
    chk("R4 page index", arr_page, 24'h030A40 >> 9);
    // R8: writes while busy are dropped
    rw(2'd0, 16'h4001);
    rw(2'd2, 16'h00FF);
    bw(16'h0000, 24'hFFFFFF);
    keys();
    chk("R8 op frozen", ctrl_rd[3:0], 4'b0010);
    wait_idle();
    chk("R7 start self-cleared", ctrl_rd[15], 0);
    // R8/R9: keys written while busy did not arm
    rw(2'd0, 16'hC042);
    chk("R9 no fresh keys", busy, 0);
    chk("R3 flag set", key_err, 1);

    // R5/R11: full row program
    for (int i = 0; i < RW; i++) bw(16'h1200 + 16'(i), 24'(i * 24'h1111 + 5));
    rw(2'd2, 16'h0007);
    keys();
    rw(2'd0, 16'hC001);
    chk("R5 program accepted", busy, 1);
    chk("R10 row index", arr_row, 24'h07123F >> 6);
    wait_idle();

    // R6 rejects: empty buffer, write-enable clear, unknown code
    keys();
    rw(2'd0, 16'hC001);
    chk("R6 incomplete buffer", busy, 0);
    chk("R6 start reads 0", ctrl_rd[15], 0);
    keys();
    rw(2'd0, 16'h8042);
    chk("R6 wren clear", busy, 0);
    keys();
    rw(2'd0, 16'hC003);
    chk("R6 bad code", busy, 0);

    // R3 broken sequences
    rw(2'd1, 16'h0055); rw(2'd1, 16'h0012); rw(2'd1, 16'h00AA);
    rw(2'd0, 16'hC042);
    chk("R3 wrong key", busy, 0);
    rw(2'd1, 16'h0055); rw(2'd2, 16'h0003); rw(2'd1, 16'h00AA);
    rw(2'd0, 16'hC042);
    chk("R3 write between keys", busy, 0);
    keys(); bw(16'h0001, 24'h000001);
    rw(2'd0, 16'hC042);
    chk("R3 buffer write before start", busy, 0);
    rw(2'd1, 16'h00AA); rw(2'd1, 16'h0055);
    rw(2'd0, 16'hC042);
    chk("R3 reversed keys", busy, 0);

    // R9: second start needs new keys
    keys();
    rw(2'd0, 16'hC042);
    chk("R9 first start", busy, 1);
    wait_idle();
    rw(2'd0, 16'hC042);
    chk("R9 reuse refused", busy, 0);
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule